// File: doc/BRIEF.md
# Serial DMA request decoder

This block receives serialized DMA request messages on the host side of a low-pin-count bus. Each peripheral owns one active-low request line, which the host samples on the bus clock. A message is a five-clock frame: one low start clock, a three-bit channel number sent most significant bit first, and a one-bit active flag. An active flag of 1 posts a request for that channel. An active flag of 0 withdraws a request posted earlier for that channel. After each frame the line must rest high for at least one clock.

Each request line has its own frame receiver. Every receiver is a four-state machine: `RX_IDLE` waits for a low start bit; `RX_CHAN` shifts in the channel bits; `RX_ACT` samples the flag and emits a one-cycle frame event; `RX_GAP` checks the recovery clock. The transitions are:

- `RX_IDLE` goes to `RX_CHAN` when it samples a low level.
- `RX_CHAN` goes to `RX_ACT` after the last channel bit.
- `RX_ACT` always goes to `RX_GAP`.
- `RX_GAP` always returns to `RX_IDLE`. If it samples a low level, it also raises a framing error.

A merge stage folds the frame events from all lines into a per-channel pending vector for a downstream DMA engine. The engine retires requests through a per-channel acknowledge vector. The pending vector is also offered split by channel class: byte-wide channels 0 to 3, the bus-master request on channel 4, and word-wide channels 5 to 7. A master-clear input empties the vector and aborts all partial frames.

Top module: `sdreq_decoder`

## Requirements
- R1: After reset, `pending`, `byte_pend`, `word_pend`, `bm_req` and `frame_err` are all zero.
- R2: A frame on a line is: low for one clock, then channel bits c2, c1, c0 (line level = bit value), then the flag bit (high = 1). A frame with flag 1 sets `pending[c]`. The bit reads high after the clock edge that follows the edge sampling the flag bit.
- R3: A frame with flag 0 clears `pending[c]` on the same timing as R2.
- R4: Frames for different channels accumulate, so several bits of `pending` can be high at once.
- R5: If a low level is sampled in the recovery clock after the flag bit, `frame_err[line]` pulses high for exactly one cycle. The pending vector is left as the completed frame made it, and that receiver accepts the next frame normally.
- R6: When both lines complete frames in the same clock, both updates apply. If they name the same channel, a set beats an abandon.
- R7: `ack[c]` high at a clock edge clears `pending[c]` at that edge, unless a frame sets channel c at the same edge, in which case the bit stays set.
- R8: `mclr` high at a clock edge zeroes `pending` and returns every receiver to idle, discarding any partial frame.
- R9: `byte_pend` equals `pending[3:0]`, `bm_req` equals `pending[4]`, and `word_pend` equals `pending[7:5]`.
- R10: While lines stay high and no acknowledge or master clear is applied, `pending` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear of all pending state |
| req_n | input | NUM_LINES | Active-low serial request lines, one per peripheral |
| ack | input | 8 | Per-channel acknowledge from the DMA engine |
| pending | output | 8 | Per-channel pending request vector |
| byte_pend | output | 4 | Pending bits of byte-wide channels 0 to 3 |
| word_pend | output | 3 | Pending bits of word-wide channels 5 to 7 |
| bm_req | output | 1 | Pending bus-master request (channel 4) |
| frame_err | output | NUM_LINES | One-cycle framing-error pulse per line |

## Verification
The checker watches four things on every cycle:

- the pending vector against the frame events the receivers emit;
- set-over-abandon and set-over-acknowledge priority;
- the effect of master clear;
- the single-cycle shape of error and frame pulses.

Only the bench scenarios can show that a serial bit stream actually decodes to the right channel, most significant bit first. The same applies to the exact latency from flag bit to pending bit, recovery after a framing error, and that a frame cut by master clear leaves no trace.

// File: rtl/sdreq_pkg.sv
package sdreq_pkg;
    localparam int CH_BITS = 3;
    localparam int NCH     = 1 << CH_BITS;
    localparam int BM_CH   = 4;
    localparam int WORD_W  = NCH - BM_CH - 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_CHAN,
        RX_ACT,
        RX_GAP
    } rx_state_e;
endpackage

// File: rtl/sdreq_frame_rx.sv
module sdreq_frame_rx
    import sdreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic               line_n,
    output logic               frm_vld,
    output logic [CH_BITS-1:0] frm_chan,
    output logic               frm_act,
    output logic               frm_err
);
    localparam int CNT_W = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CH_BITS - 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CH_BITS-1:0] shift_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else if (mclr) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (!line_n) state_d = RX_CHAN;
            RX_CHAN: if (bit_cnt == LAST_BIT) state_d = RX_ACT;
            RX_ACT:  state_d = RX_GAP;
            RX_GAP:  state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            frm_vld  <= 1'b0;
            frm_chan <= '0;
            frm_act  <= 1'b0;
            frm_err  <= 1'b0;
        end else if (mclr) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            frm_vld  <= 1'b0;
            frm_act  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            frm_err <= 1'b0;
            unique case (state_q)
                RX_IDLE: bit_cnt <= '0;
                RX_CHAN: begin
                    shift_q <= {shift_q[CH_BITS-2:0], line_n};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                RX_ACT: begin
                    frm_vld  <= 1'b1;
                    frm_chan <= shift_q;
                    frm_act  <= line_n;
                end
                RX_GAP:  frm_err <= ~line_n;
                default: bit_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sdreq_pending.sv
module sdreq_pending
    import sdreq_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mclr,
    input  logic [NUM_LINES-1:0]              frm_vld,
    input  logic [NUM_LINES-1:0][CH_BITS-1:0] frm_chan,
    input  logic [NUM_LINES-1:0]              frm_act,
    input  logic [NCH-1:0]                    ack,
    output logic [NCH-1:0]                    pending
);
    logic [NCH-1:0] set_m, abd_m;

    always_comb begin
        set_m = '0;
        abd_m = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (frm_vld[l]) begin
                if (frm_act[l]) set_m[frm_chan[l]] = 1'b1;
                else            abd_m[frm_chan[l]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (mclr) begin
            pending <= '0;
        end else begin
            pending <= (pending & ~abd_m & ~ack) | set_m;
        end
    end
endmodule

// File: rtl/sdreq_class.sv
module sdreq_class
    import sdreq_pkg::*;
(
    input  logic [NCH-1:0]    pending,
    output logic [BM_CH-1:0]  byte_pend,
    output logic              bm_req,
    output logic [WORD_W-1:0] word_pend
);
    assign byte_pend = pending[BM_CH-1:0];
    assign bm_req    = pending[BM_CH];
    assign word_pend = pending[NCH-1:BM_CH+1];
endmodule

// File: rtl/sdreq_decoder.sv
module sdreq_decoder
    import sdreq_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mclr,
    input  logic [NUM_LINES-1:0] req_n,
    input  logic [NCH-1:0]       ack,
    output logic [NCH-1:0]       pending,
    output logic [BM_CH-1:0]     byte_pend,
    output logic [WORD_W-1:0]    word_pend,
    output logic                 bm_req,
    output logic [NUM_LINES-1:0] frame_err
);
    logic [NUM_LINES-1:0]              frm_vld;
    logic [NUM_LINES-1:0][CH_BITS-1:0] frm_chan;
    logic [NUM_LINES-1:0]              frm_act;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_rx
        sdreq_frame_rx u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .mclr     (mclr),
            .line_n   (req_n[l]),
            .frm_vld  (frm_vld[l]),
            .frm_chan (frm_chan[l]),
            .frm_act  (frm_act[l]),
            .frm_err  (frame_err[l])
        );
    end

    sdreq_pending #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .frm_vld  (frm_vld),
        .frm_chan (frm_chan),
        .frm_act  (frm_act),
        .ack      (ack),
        .pending  (pending)
    );

    sdreq_class u_class (
        .pending   (pending),
        .byte_pend (byte_pend),
        .bm_req    (bm_req),
        .word_pend (word_pend)
    );
endmodule

// File: rtl/sdreq_decoder_chk.sv
module sdreq_decoder_chk
    import sdreq_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              mclr,
    input logic [NCH-1:0]                    ack,
    input logic [NCH-1:0]                    pending,
    input logic [NUM_LINES-1:0]              frame_err,
    input logic [NUM_LINES-1:0]              frm_vld,
    input logic [NUM_LINES-1:0][CH_BITS-1:0] frm_chan,
    input logic [NUM_LINES-1:0]              frm_act
);
    logic [NCH-1:0] want_set, want_abd;

    always_comb begin
        want_set = '0;
        want_abd = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (frm_vld[l] && frm_act[l])  want_set[frm_chan[l]] = 1'b1;
            if (frm_vld[l] && !frm_act[l]) want_abd[frm_chan[l]] = 1'b1;
        end
    end

    AST_MCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (pending == '0)); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (want_set[c] && !mclr) |=> pending[c]); // R6
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[c] && !want_set[c]) |=> !pending[c]); // R7
        AST_ABANDON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (want_abd[c] && !want_set[c]) |=> !pending[c]); // R3
        AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!mclr && !ack[c] && !want_set[c] && !want_abd[c]) |=> $stable(pending[c])); // R10
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln
        AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            frame_err[l] |=> !frame_err[l]); // R5
        AST_ERR_APART_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
            frame_err[l] |-> !frm_vld[l]); // R5
        AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            frm_vld[l] |=> !frm_vld[l]); // R2
    end
endmodule

bind sdreq_decoder sdreq_decoder_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .ack       (ack),
    .pending   (pending),
    .frame_err (frame_err),
    .frm_vld   (frm_vld),
    .frm_chan  (frm_chan),
    .frm_act   (frm_act)
);

// File: tb/sdreq_decoder_test.sv
module sdreq_decoder_test;
    import sdreq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 2;
    localparam logic [4:0] IDLE_F = 5'b11111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mclr = 1'b0;
    logic [NL-1:0] req_n = '1;
    logic [NCH-1:0] ack = '0;
    logic [NCH-1:0] pending;
    logic [BM_CH-1:0] byte_pend;
    logic [WORD_W-1:0] word_pend;
    logic          bm_req;
    logic [NL-1:0] frame_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdreq_decoder #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .req_n(req_n), .ack(ack),
        .pending(pending), .byte_pend(byte_pend), .word_pend(word_pend),
        .bm_req(bm_req), .frame_err(frame_err)
    );

    function automatic logic [4:0] frm(input logic [2:0] ch, input logic act);
        return {1'b0, ch, act};
    endfunction

    task automatic chk(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // drives five frame bits on each line, then the recovery clock with gap
    // levels and acknowledge; returns one negedge after the recovery clock
    task automatic xfer(input logic [4:0] f0, input logic [4:0] f1,
                        input logic g0, input logic g1, input logic [7:0] ackv);
        for (int i = 4; i >= 0; i--) begin
            @(negedge clk);
            req_n = {f1[i], f0[i]};
        end
        @(negedge clk);
        req_n = {g1, g0};
        ack = ackv;
        @(negedge clk);
        req_n = '1;
        ack = '0;
    endtask

    task automatic t_reset();
        chk("R1 pending", pending, 8'h00);
        chk("R1 frame_err", {6'b0, frame_err}, 8'h00);
        chk("R1 class", {byte_pend, word_pend, bm_req}, 8'h00);
    endtask

    task automatic t_idle();
        repeat (12) @(negedge clk);
        chk("R10 idle lines", pending, 8'h00);
    endtask

    task automatic t_single();
        xfer(frm(3'd5, 1'b1), IDLE_F, 1'b1, 1'b1, 8'h00);
        chk("R2 set ch5", pending, 8'h20);
        chk("R9 word_pend", {5'b0, word_pend}, 8'h01);
        chk("R9 byte/bm zero", {3'b0, bm_req, byte_pend}, 8'h00);
    endtask

    task automatic t_queue();
        xfer(frm(3'd1, 1'b1), IDLE_F, 1'b1, 1'b1, 8'h00);
        xfer(frm(3'd3, 1'b1), IDLE_F, 1'b1, 1'b1, 8'h00);
        chk("R4 queued ch1 ch3", pending, 8'h2A);
        xfer(IDLE_F, frm(3'd4, 1'b1), 1'b1, 1'b1, 8'h00);
        chk("R9 bm_req", {7'b0, bm_req}, 8'h01);
        chk("R9 byte_pend", {4'b0, byte_pend}, 8'h0A);
        chk("R4 pending", pending, 8'h3A);
    endtask

    task automatic t_abandon();
        xfer(frm(3'd3, 1'b0), IDLE_F, 1'b1, 1'b1, 8'h00);
        chk("R3 abandon ch3", pending, 8'h32);
    endtask

    task automatic t_gap_err();
        xfer(IDLE_F, frm(3'd0, 1'b1), 1'b1, 1'b0, 8'h00);
        chk("R5 err pulse", {6'b0, frame_err}, 8'h02);
        chk("R5 pending kept", pending, 8'h33);
        @(negedge clk);
        chk("R5 err one cycle", {6'b0, frame_err}, 8'h00);
        xfer(IDLE_F, frm(3'd6, 1'b1), 1'b1, 1'b1, 8'h00);
        chk("R5 recovery frame", pending, 8'h73);
        chk("R5 no err", {6'b0, frame_err}, 8'h00);
    endtask

    task automatic t_dual();
        xfer(frm(3'd2, 1'b1), frm(3'd7, 1'b1), 1'b1, 1'b1, 8'h00);
        chk("R6 both set", pending, 8'hF7);
        xfer(frm(3'd2, 1'b0), frm(3'd2, 1'b1), 1'b1, 1'b1, 8'h00);
        chk("R6 set beats abandon", pending, 8'hF7);
        xfer(frm(3'd7, 1'b0), frm(3'd6, 1'b0), 1'b1, 1'b1, 8'h00);
        chk("R6 both abandon", pending, 8'h37);
    endtask

    task automatic t_ack();
        @(negedge clk);
        ack = 8'h01;
        @(negedge clk);
        ack = '0;
        chk("R7 ack ch0", pending, 8'h36);
        xfer(frm(3'd0, 1'b1), IDLE_F, 1'b1, 1'b1, 8'h21);
        chk("R7 set beats ack", pending, 8'h17);
    endtask

    task automatic t_mclr();
        @(negedge clk);
        req_n[0] = 1'b0;
        @(negedge clk);
        req_n[0] = 1'b1;
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
        chk("R8 mclr empties", pending, 8'h00);
        repeat (6) @(negedge clk);
        chk("R8 partial frame dropped", pending, 8'h00);
        chk("R8 no err", {6'b0, frame_err}, 8'h00);
        xfer(frm(3'd6, 1'b1), IDLE_F, 1'b1, 1'b1, 8'h00);
        chk("R8 receiver idle after clear", pending, 8'h40);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        t_single();
        t_queue();
        t_abandon();
        t_gap_err();
        t_dual();
        t_ack();
        t_mclr();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end
endmodule